// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave (I2C, block protocol)

This block is the serial configuration port of a clock generator. It sits on a two-wire I2C bus as a slave and holds seven 8-bit configuration registers. Downstream logic reads these registers in parallel, for example as output-enable and frequency-select fields. The block samples SCL and SDA on a fast system clock and pulls SDA low through an open-drain output.

The block keeps no register pointer. A write transaction always opens with two header bytes, a command code and a byte count. The slave acknowledges both and throws their contents away. The data bytes that follow land in register 0, then register 1 and upward, until the host issues STOP. A read transaction has no command phase. The slave first sends the byte count and then streams the whole register bank, starting at register 0. The host acknowledges each byte and ends the transfer by not acknowledging, or with STOP.

The bus clock must stay at or below the standard-mode rate of 100 kbit/s. The system clock must run at least ten times faster than SCL, and each SCL phase must last at least six system clocks.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (7-bit address 0x69, write) and the address byte 0xD3 (same address, read). Any other address byte is not acknowledged, and the rest of that transaction leaves the registers and SDA untouched.
- R2: In a write, the two bytes after the address are both acknowledged and neither is stored. The first data byte after them always goes to register 0.
- R3: Write data bytes arrive MSB first. Each one is acknowledged and stored in ascending register order, starting at register 0. Register k appears on `cfg_regs_o[8k+7:8k]`.
- R4: A STOP after any complete data byte keeps every byte already received. Registers not yet reached keep their old values. Register outputs only change while SCL is low.
- R5: A read returns the byte count 0x07 first, then registers 0 through 6 in order, MSB first, continuing as long as the host acknowledges.
- R6: Reset loads the register bank with the defaults 0x11, 0x7F, 0xFF, 0xF0, 0xFF, 0xFF and 0x00 for registers 0 to 6, and leaves SDA released.
- R7: Write data bytes beyond register 6 are still acknowledged but are discarded. Registers 0 to 6 keep the values from the first seven data bytes.
- R8: When the host does not acknowledge a read byte, the slave releases SDA within a few system clocks and waits for STOP or START. A later transaction works normally.
- R9: A START in the middle of a transaction abandons it. A partly received data byte is not stored, and address reception restarts at once.
- R10: The SDA drive only goes active while SCL is low, and SDA is released after every STOP.
- R11: Read bytes requested after register 6 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled SCL bus line |
| sda_i | input | 1 | Sampled SDA bus line (wired-AND of all drivers) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_regs_o | output | 56 | Register bank, register k in bits 8k+7:8k |

## Verification
The hardest situation to reach from the ports is a repeated START that lands halfway through a write data byte. The slave then has some bits shifted in but nothing committed. The bench gets there by sending the write address and both header bytes, clocking out four bits of a data byte, then raising SDA while SCL is low and pulling it down while SCL is high. It then reads back over the new read transaction to confirm that no register moved. The host NACK case is reached the same way. The bench refuses the byte count and then watches the SDA drive while SCL is still low.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACK,
    PH_SEND,
    PH_HACK
  } phase_t;
endpackage

// File: rtl/cfgi2c_line_mon.sv
module cfgi2c_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_meta, scl_sync, scl_prev;
  logic sda_meta, sda_sync, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_meta <= 1'b1;
      scl_sync <= 1'b1;
      scl_prev <= 1'b1;
      sda_meta <= 1'b1;
      sda_sync <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_meta <= scl_i;
      scl_sync <= scl_meta;
      scl_prev <= scl_sync;
      sda_meta <= sda_i;
      sda_sync <= sda_meta;
      sda_prev <= sda_sync;
    end
  end

  assign sda_s     = sda_sync;
  assign scl_rise  = scl_sync & ~scl_prev;
  assign scl_fall  = ~scl_sync & scl_prev;
  // bus conditions: SDA moves while SCL stays high
  assign start_evt = scl_sync & scl_prev & sda_prev & ~sda_sync;
  assign stop_evt  = scl_sync & scl_prev & ~sda_prev & sda_sync;
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
  parameter int unsigned NREG  = 7,
  parameter int unsigned RIDXW = 3,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RIDXW-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    logic       hit;
    assign hit = wr_en && (wr_idx == RIDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= DEFAULTS[g*8 +: 8];
      else if (hit) q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end
endmodule

// File: rtl/cfgi2c_proto.sv
module cfgi2c_proto
  import cfgi2c_pkg::*;
#(
  parameter int unsigned NREG     = 7,
  parameter int unsigned RIDXW    = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [NREG*8-1:0] regs_flat,
  output logic              drive_low,
  output logic              wr_en,
  output logic [RIDXW-1:0]  wr_idx,
  output logic [7:0]        wr_data
);
  localparam int unsigned CNTW = $clog2(NREG + 3) + 1;
  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

  phase_t          ph_q, ph_n;
  logic [3:0]      bit_q, bit_n;
  logic [7:0]      sh_q, sh_n;
  logic [CNTW-1:0] idx_q, idx_n, idx_inc;
  logic            addr_q, addr_n;
  logic            rd_q, rd_n;
  logic            drv_q, drv_n;
  logic            hack_q, hack_n;
  logic [7:0]      tx_cur, tx_nxt;

  // byte index 0 is the count; index k in 1..NREG is register k-1
  function automatic logic [7:0] tx_pick(input logic [CNTW-1:0] i,
                                         input logic [NREG*8-1:0] r);
    logic [7:0] b;
    b = 8'hFF;
    if (i == '0) b = 8'(NREG);
    for (int k = 0; k < NREG; k++)
      if (i == CNTW'(k + 1)) b = r[k*8 +: 8];
    return b;
  endfunction

  assign idx_inc = (idx_q == CMAX) ? idx_q : idx_q + 1'b1;
  assign tx_cur  = tx_pick(idx_q, regs_flat);
  assign tx_nxt  = tx_pick(idx_inc, regs_flat);

  always_comb begin
    ph_n    = ph_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    idx_n   = idx_q;
    addr_n  = addr_q;
    rd_n    = rd_q;
    drv_n   = drv_q;
    hack_n  = hack_q;
    wr_en   = 1'b0;
    wr_idx  = RIDXW'(idx_q - CNTW'(2));
    wr_data = sh_q;
    if (start_evt) begin
      ph_n   = PH_RECV;
      addr_n = 1'b1;
      rd_n   = 1'b0;
      bit_n  = '0;
      idx_n  = '0;
      drv_n  = 1'b0;
    end else if (stop_evt) begin
      ph_n  = PH_IDLE;
      drv_n = 1'b0;
    end else begin
      unique case (ph_q)
        PH_RECV: begin
          if (scl_rise && bit_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (addr_q) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                ph_n   = PH_ACK;
                drv_n  = 1'b1;
                rd_n   = sh_q[0];
                addr_n = 1'b0;
              end else begin
                ph_n = PH_IDLE;
              end
            end else begin
              ph_n  = PH_ACK;
              drv_n = 1'b1;
              wr_en = (idx_q >= CNTW'(2)) && (idx_q < CNTW'(NREG + 2));
              idx_n = idx_inc;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (rd_q) begin
              sh_n  = tx_cur;
              drv_n = ~tx_cur[7];
              bit_n = 4'd1;
              ph_n  = PH_SEND;
            end else begin
              drv_n = 1'b0;
              ph_n  = PH_RECV;
            end
          end
        end
        PH_SEND: begin
          if (scl_fall) begin
            if (bit_q == 4'd8) begin
              drv_n = 1'b0;
              ph_n  = PH_HACK;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              drv_n = ~sh_q[6];
              bit_n = bit_q + 4'd1;
            end
          end
        end
        PH_HACK: begin
          if (scl_rise) begin
            hack_n = sda_s;
          end else if (scl_fall) begin
            if (!hack_q) begin
              idx_n = idx_inc;
              sh_n  = tx_nxt;
              drv_n = ~tx_nxt[7];
              bit_n = 4'd1;
              ph_n  = PH_SEND;
            end else begin
              ph_n = PH_IDLE;
            end
          end
        end
        default: begin
          drv_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      addr_q <= 1'b0;
      rd_q   <= 1'b0;
      drv_q  <= 1'b0;
      hack_q <= 1'b1;
    end else begin
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      idx_q  <= idx_n;
      addr_q <= addr_n;
      rd_q   <= rd_n;
      drv_q  <= drv_n;
      hack_q <= hack_n;
    end
  end

  assign drive_low = drv_q;
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int unsigned NREG     = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] DEFAULTS =
    {8'h00, 8'hFF, 8'hFF, 8'hF0, 8'hFF, 8'h7F, 8'h11}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  output logic [NREG*8-1:0] cfg_regs_o
);
  localparam int unsigned RIDXW = $clog2(NREG + 1);

  logic             rst_meta, rst_s_n;
  logic             sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en;
  logic [RIDXW-1:0] wr_idx;
  logic [7:0]       wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  cfgi2c_line_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  cfgi2c_proto #(.NREG(NREG), .RIDXW(RIDXW), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .regs_flat (cfg_regs_o),
    .drive_low (sda_drive_low_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  cfgi2c_regbank #(.NREG(NREG), .RIDXW(RIDXW), .DEFAULTS(DEFAULTS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .regs_flat (cfg_regs_o)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int unsigned NREG  = 7,
  parameter int unsigned RIDXW = 3
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              scl_i,
  input logic              sda_drive_low_o,
  input logic [NREG*8-1:0] cfg_regs_o,
  input logic              stop_evt,
  input logic              wr_en,
  input logic [RIDXW-1:0]  wr_idx
);
  // R10
  drive_on_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(sda_drive_low_o) |-> !scl_i);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    stop_evt |=> !sda_drive_low_o);

  // R4
  regs_move_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(cfg_regs_o) |-> !scl_i);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_en |-> (wr_idx < RIDXW'(NREG)));

  // R4
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_en |=> $stable(cfg_regs_o));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NREG(NREG), .RIDXW(RIDXW)) u_chk (
  .clk             (clk),
  .rst_s_n         (rst_s_n),
  .scl_i           (scl_i),
  .sda_drive_low_o (sda_drive_low_o),
  .cfg_regs_o      (cfg_regs_o),
  .stop_evt        (stop_evt),
  .wr_en           (wr_en),
  .wr_idx          (wr_idx)
);

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
  localparam int Q = 16;

  logic        clk;
  logic        rst_n;
  logic        scl;
  logic        m_sda;
  logic        sda_drv;
  logic [55:0] regs;
  logic        sda_line;
  logic [7:0]  model [7];
  int          n_chk;
  int          n_fail;

  assign sda_line = m_sda & ~sda_drv;

  cfg_i2c_slave dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl),
    .sda_i           (sda_line),
    .sda_drive_low_o (sda_drv),
    .cfg_regs_o      (regs)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    m_sda = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;  wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    ack = ~sda_line; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1;
      wq(Q); b[i] = sda_line;
      wq(Q); scl = 1'b0;
      wq(Q);
    end
    m_sda = nack; wq(Q);
    scl = 1'b1;   wq(2*Q);
    scl = 1'b0;   wq(Q);
    m_sda = 1'b1;
  endtask

  task automatic check_bank(input string tag);
    for (int k = 0; k < 7; k++) check(tag, regs[k*8 +: 8], model[k]);
  endtask

  task automatic write_seq(input int nbytes, input logic [7:0] base, input string tag);
    logic ack;
    i2c_start;
    wr_byte(8'hD2, ack); check("R1", ack, 1'b1);
    wr_byte(8'h9E, ack); check("R2", ack, 1'b1);
    wr_byte(8'h3B, ack); check("R2", ack, 1'b1);
    for (int k = 0; k < nbytes; k++) begin
      wr_byte(base + 8'(k * 17), ack);
      check(tag, ack, 1'b1);
      if (k < 7) model[k] = base + 8'(k * 17);
    end
    i2c_stop;
    wq(8);
  endtask

  task automatic t_reset;
    model = '{8'h11, 8'h7F, 8'hFF, 8'hF0, 8'hFF, 8'hFF, 8'h00};
    check_bank("R6");
    check("R6", sda_drv, 1'b0);
  endtask

  task automatic t_write_all;
    write_seq(7, 8'hA1, "R3");
    check("R2", regs[7:0], 8'hA1);
    check_bank("R3");
  endtask

  task automatic t_partial;
    write_seq(2, 8'h24, "R4");
    check_bank("R4");
  endtask

  task automatic t_overflow;
    write_seq(9, 8'h05, "R7");
    check_bank("R7");
  endtask

  task automatic t_read_all;
    logic ack;
    logic [7:0] b;
    i2c_start;
    wr_byte(8'hD3, ack); check("R1", ack, 1'b1);
    rd_byte(1'b0, b); check("R5", b, 8'h07);
    for (int k = 0; k < 7; k++) begin
      rd_byte(1'b0, b);
      check("R5", b, model[k]);
    end
    rd_byte(1'b1, b); check("R11", b, 8'hFF);
    i2c_stop;
    wq(8);
    check("R10", sda_drv, 1'b0);
    check_bank("R5");
  endtask

  task automatic t_foreign;
    logic ack;
    i2c_start;
    wr_byte(8'hA4, ack); check("R1", ack, 1'b0);
    wr_byte(8'h00, ack); check("R1", ack, 1'b0);
    wr_byte(8'h00, ack); check("R1", ack, 1'b0);
    wr_byte(8'h00, ack); check("R1", ack, 1'b0);
    i2c_stop;
    i2c_start;
    wr_byte(8'hD0, ack); check("R1", ack, 1'b0);
    wr_byte(8'h00, ack);
    i2c_stop;
    wq(8);
    check_bank("R1");
  endtask

  task automatic t_nack;
    logic ack;
    logic [7:0] b;
    i2c_start;
    wr_byte(8'hD3, ack); check("R8", ack, 1'b1);
    rd_byte(1'b1, b); check("R8", b, 8'h07);
    wq(8);
    check("R8", sda_drv, 1'b0);
    send_bit(1'b1);
    check("R8", sda_drv, 1'b0);
    i2c_stop;
    wq(8);
  endtask

  task automatic t_restart;
    logic ack;
    logic [7:0] b;
    i2c_start;
    wr_byte(8'hD2, ack);
    wr_byte(8'h01, ack);
    wr_byte(8'h02, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_start;
    wr_byte(8'hD3, ack); check("R9", ack, 1'b1);
    rd_byte(1'b0, b); check("R9", b, 8'h07);
    rd_byte(1'b1, b); check("R9", b, model[0]);
    i2c_stop;
    wq(8);
    check_bank("R9");
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    scl    = 1'b1;
    m_sda  = 1'b1;
    rst_n  = 1'b0;
    wq(5);
    rst_n  = 1'b1;
    wq(10);
    t_reset;
    t_write_all;
    t_read_all;
    t_partial;
    t_overflow;
    t_foreign;
    t_nack;
    t_read_all;
    t_restart;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule